// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank with Wakeup

A bank of general-purpose I/O lines behind a simple 32-bit register port. Each line is either an input or a driven output, chosen per bit by an output-enable register in which a 1 makes the line an input. Input lines feed an event detector that can watch, per line, for a high level, a low level, a rising edge and a falling edge. Every detected event is latched into two separate status registers. Each status register has its own enable register and its own interrupt output, so two consumers can each take and acknowledge the same events on their own.

Enable registers, the wakeup-enable register and the output-data register each have a pair of alias addresses. Writing a 1 to a bit at one alias sets that bit, and writing a 1 at the other clears it. No read-modify-write is needed. The bank raises a sticky wakeup request when an enabled line sees an event while the configuration allows wakeup. Debounce enable and debounce time are storage only.

The register port has a one-cycle read latency. `bus_rdata` is registered on the cycle the read is issued. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are high.

Top module: `gpio_dual_irq_bank`

## Requirements
- R1: After reset, output enable (0x34) reads 0xFFFFFFFF, control (0x30) reads 2 and system status (0x14) reads 1. Revision (0x00) reads the REVISION parameter (default 0x25). Configuration, both status registers, both enables, wakeup enable, the four detect registers and both debounce registers read 0. `irq_a`, `irq_b`, `wake_req` and `pad_drive` are 0.
- R2: Configuration (0x10) stores only the bits in mask 0x1D. Control (0x30) stores only bits 2:0. Debounce enable (0x50) stores 32 bits. Debounce time (0x54) stores bits 7:0. None of these registers filters an input.
- R3: For enable A the clear/set aliases are 0x60/0x64, for enable B 0x70/0x74, for wakeup enable 0x80/0x84 and for data out 0x90/0x94. Enable A lives at 0x1C, enable B at 0x2C, wakeup enable at 0x20 and data out at 0x3C. A 1 written at an alias clears or sets that bit and leaves the other bits alone. A read of an alias returns the underlying register.
- R4: Revision, system status and data in (0x38) ignore writes. Data in reads the current level of `pin_in`.
- R5: On an input line, a rising edge with its bit set in the rising register (0x48) sets that bit in both status A (0x18) and status B (0x28). The same holds for a falling edge with its bit set in the falling register (0x4C).
- R6: On an input line, a high level with its bit set in the level-high register (0x44) sets both status bits, and so does a low level with its bit set in the level-low register (0x40). The condition is evaluated every cycle, so a cleared status bit comes back at once while its level still holds.
- R7: Lines whose output-enable bit is 0 produce no events. On those lines `pad_drive` is 1 and `pad_out` carries data out.
- R8: `irq_a` is 1 exactly when status A AND enable A is nonzero. `irq_b` is 1 exactly when status B AND enable B is nonzero.
- R9: Writing 1s to a status register clears those bits. Bits written 0, and the other status register, are unchanged.
- R10: Writing configuration with bit 1 set returns every register to its reset value, then stores the written value masked with 0x1D as configuration.
- R11: `wake_req` rises when an event occurs on a line whose wakeup-enable bit is 1, provided configuration bit 2 is 1 and bits 4:3 are nonzero (the value 3 is illegal but still counts). It then stays 1 until a write to the wakeup-enable clear alias (0x80) or a reset.
- R12: Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| pin_in | input | 32 | Sampled line levels |
| pad_out | output | 32 | Output data for the lines |
| pad_drive | output | 32 | 1 where a line is driven |
| irq_a | output | 1 | Interrupt for status/enable pair A |
| irq_b | output | 1 | Interrupt for status/enable pair B |
| wake_req | output | 1 | Sticky wakeup request |

## Verification
Random trials each pick a start pattern and an end pattern for the lines, together with random output-enable, rising, falling, level-high and level-low masks. The expected status is the union of the level matches of both patterns and the edge matches of the transition between them. Checking that one formula on many trials tells edge detection apart from level detection and masked lines apart from unmasked ones. Directed cases then cover:
- a level source coming back after a clear, and a status bit staying cleared once its level has gone;
- the two status registers being cleared independently;
- wakeup with the idle-mode field at zero, where no request may appear, against a nonzero field, where the request must appear;
- aliases leaving their untouched bits alone.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_REV    = 8'h00;
  localparam logic [ADDR_W-1:0] A_CFG    = 8'h10;
  localparam logic [ADDR_W-1:0] A_SSTAT  = 8'h14;
  localparam logic [ADDR_W-1:0] A_STA    = 8'h18;
  localparam logic [ADDR_W-1:0] A_ENA    = 8'h1C;
  localparam logic [ADDR_W-1:0] A_WEN    = 8'h20;
  localparam logic [ADDR_W-1:0] A_STB    = 8'h28;
  localparam logic [ADDR_W-1:0] A_ENB    = 8'h2C;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h30;
  localparam logic [ADDR_W-1:0] A_OE     = 8'h34;
  localparam logic [ADDR_W-1:0] A_DIN    = 8'h38;
  localparam logic [ADDR_W-1:0] A_DOUT   = 8'h3C;
  localparam logic [ADDR_W-1:0] A_LLO    = 8'h40;
  localparam logic [ADDR_W-1:0] A_LHI    = 8'h44;
  localparam logic [ADDR_W-1:0] A_RISE   = 8'h48;
  localparam logic [ADDR_W-1:0] A_FALL   = 8'h4C;
  localparam logic [ADDR_W-1:0] A_DBEN   = 8'h50;
  localparam logic [ADDR_W-1:0] A_DBT    = 8'h54;
  localparam logic [ADDR_W-1:0] A_ENA_C  = 8'h60;
  localparam logic [ADDR_W-1:0] A_ENA_S  = 8'h64;
  localparam logic [ADDR_W-1:0] A_ENB_C  = 8'h70;
  localparam logic [ADDR_W-1:0] A_ENB_S  = 8'h74;
  localparam logic [ADDR_W-1:0] A_WEN_C  = 8'h80;
  localparam logic [ADDR_W-1:0] A_WEN_S  = 8'h84;
  localparam logic [ADDR_W-1:0] A_DOUT_C = 8'h90;
  localparam logic [ADDR_W-1:0] A_DOUT_S = 8'h94;

  localparam int CFG_W = 5;
  localparam logic [CFG_W-1:0] CFG_KEEP = 5'h1D;
  localparam int CFG_SRST_BIT = 1;
  localparam int CFG_WAKE_BIT = 2;
  localparam int CTRL_W = 3;
  localparam logic [CTRL_W-1:0] CTRL_RST = 3'd2;
endpackage

// File: rtl/gpio_event_det.sv
module gpio_event_det #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pin_in,
  input  logic [NLINES-1:0] is_input,
  input  logic [NLINES-1:0] det_rise,
  input  logic [NLINES-1:0] det_fall,
  input  logic [NLINES-1:0] det_high,
  input  logic [NLINES-1:0] det_low,
  output logic [NLINES-1:0] event_hit
);
  logic [NLINES-1:0] pin_prev;

  always_ff @(posedge clk) begin
    if (rst) pin_prev <= '0;
    else     pin_prev <= pin_in;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic up, down;
    assign up   = pin_in[i] & ~pin_prev[i];
    assign down = ~pin_in[i] & pin_prev[i];
    assign event_hit[i] = is_input[i] &
                          ((up & det_rise[i]) | (down & det_fall[i]) |
                           (pin_in[i] & det_high[i]) | (~pin_in[i] & det_low[i]));
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NLINES   = 32,
  parameter int DBT_W    = 8,
  parameter int REVISION = 32'h25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  input  logic [NLINES-1:0] event_hit,
  output logic [NLINES-1:0] oe_q,
  output logic [NLINES-1:0] dout_q,
  output logic [NLINES-1:0] rise_q,
  output logic [NLINES-1:0] fall_q,
  output logic [NLINES-1:0] lhi_q,
  output logic [NLINES-1:0] llo_q,
  output logic [NLINES-1:0] st_a_q,
  output logic [NLINES-1:0] st_b_q,
  output logic [NLINES-1:0] en_a_q,
  output logic [NLINES-1:0] en_b_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              irq_a_q,
  output logic              irq_b_q,
  output logic              wake_q
);
  logic [NLINES-1:0] wen_q, dben_q;
  logic [DBT_W-1:0]  dbt_q;
  logic [CTRL_W-1:0] ctrl_q;

  logic [NLINES-1:0] wd;
  logic wr, rd, srst;
  assign wr   = bus_sel & bus_wr;
  assign rd   = bus_sel & ~bus_wr;
  assign wd   = bus_wdata[NLINES-1:0];
  assign srst = wr && (bus_addr == A_CFG) && bus_wdata[CFG_SRST_BIT];

  function automatic logic [NLINES-1:0] upd(input logic [NLINES-1:0] cur,
      input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] a_w,
      input logic [ADDR_W-1:0] a_c, input logic [ADDR_W-1:0] a_s,
      input logic [NLINES-1:0] v);
    if (a == a_w)      return v;
    else if (a == a_c) return cur & ~v;
    else if (a == a_s) return cur | v;
    else               return cur;
  endfunction

  logic [NLINES-1:0] st_a_n, st_b_n, en_a_n, en_b_n, wen_n;
  logic wake_set, wake_clr, wake_n, wake_ok;

  assign wake_ok  = cfg_q[CFG_WAKE_BIT] && (cfg_q[4:3] != 2'b00);
  assign wake_set = wake_ok && |(event_hit & wen_q);
  assign wake_clr = wr && (bus_addr == A_WEN_C);

  always_comb begin
    st_a_n = (st_a_q & ~((wr && bus_addr == A_STA) ? wd : '0)) | event_hit;
    st_b_n = (st_b_q & ~((wr && bus_addr == A_STB) ? wd : '0)) | event_hit;
    en_a_n = wr ? upd(en_a_q, bus_addr, A_ENA, A_ENA_C, A_ENA_S, wd) : en_a_q;
    en_b_n = wr ? upd(en_b_q, bus_addr, A_ENB, A_ENB_C, A_ENB_S, wd) : en_b_q;
    wen_n  = wr ? upd(wen_q, bus_addr, A_WEN, A_WEN_C, A_WEN_S, wd) : wen_q;
    wake_n = (wake_q & ~wake_clr) | wake_set;
    if (srst) begin
      st_a_n = '0; st_b_n = '0; en_a_n = '0; en_b_n = '0; wake_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_a_q <= '0; st_b_q <= '0; en_a_q <= '0; en_b_q <= '0;
      wen_q  <= '0; wake_q <= 1'b0; irq_a_q <= 1'b0; irq_b_q <= 1'b0;
    end else begin
      st_a_q  <= st_a_n;
      st_b_q  <= st_b_n;
      en_a_q  <= en_a_n;
      en_b_q  <= en_b_n;
      wen_q   <= srst ? '0 : wen_n;
      wake_q  <= wake_n;
      irq_a_q <= |(st_a_n & en_a_n);
      irq_b_q <= |(st_b_n & en_b_n);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      oe_q <= '1; dout_q <= '0; rise_q <= '0; fall_q <= '0;
      lhi_q <= '0; llo_q <= '0; dben_q <= '0; dbt_q <= '0;
      ctrl_q <= CTRL_RST;
      cfg_q <= rst ? '0 : (bus_wdata[CFG_W-1:0] & CFG_KEEP);
    end else if (wr) begin
      dout_q <= upd(dout_q, bus_addr, A_DOUT, A_DOUT_C, A_DOUT_S, wd);
      case (bus_addr)
        A_CFG:  cfg_q  <= bus_wdata[CFG_W-1:0] & CFG_KEEP;
        A_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
        A_OE:   oe_q   <= wd;
        A_LLO:  llo_q  <= wd;
        A_LHI:  lhi_q  <= wd;
        A_RISE: rise_q <= wd;
        A_FALL: fall_q <= wd;
        A_DBEN: dben_q <= wd;
        A_DBT:  dbt_q  <= bus_wdata[DBT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (rd) begin
      case (bus_addr)
        A_REV:                     bus_rdata <= DATA_W'(REVISION);
        A_CFG:                     bus_rdata <= DATA_W'(cfg_q);
        A_SSTAT:                   bus_rdata <= DATA_W'(1);
        A_STA:                     bus_rdata <= DATA_W'(st_a_q);
        A_ENA, A_ENA_C, A_ENA_S:   bus_rdata <= DATA_W'(en_a_q);
        A_WEN, A_WEN_C, A_WEN_S:   bus_rdata <= DATA_W'(wen_q);
        A_STB:                     bus_rdata <= DATA_W'(st_b_q);
        A_ENB, A_ENB_C, A_ENB_S:   bus_rdata <= DATA_W'(en_b_q);
        A_CTRL:                    bus_rdata <= DATA_W'(ctrl_q);
        A_OE:                      bus_rdata <= DATA_W'(oe_q);
        A_DIN:                     bus_rdata <= DATA_W'(pin_in);
        A_DOUT, A_DOUT_C, A_DOUT_S: bus_rdata <= DATA_W'(dout_q);
        A_LLO:                     bus_rdata <= DATA_W'(llo_q);
        A_LHI:                     bus_rdata <= DATA_W'(lhi_q);
        A_RISE:                    bus_rdata <= DATA_W'(rise_q);
        A_FALL:                    bus_rdata <= DATA_W'(fall_q);
        A_DBEN:                    bus_rdata <= DATA_W'(dben_q);
        A_DBT:                     bus_rdata <= DATA_W'(dbt_q);
        default:                   bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_dual_irq_bank.sv
module gpio_dual_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NLINES   = 32,
  parameter int DBT_W    = 8,
  parameter int REVISION = 32'h25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_drive,
  output logic              irq_a,
  output logic              irq_b,
  output logic              wake_req
);
  logic [NLINES-1:0] oe, dout, rise, fall, lhi, llo, hit;
  logic [NLINES-1:0] st_a, st_b, en_a, en_b;
  logic [CFG_W-1:0]  cfg;

  gpio_event_det #(.NLINES(NLINES)) u_det (
    .clk(clk), .rst(rst), .pin_in(pin_in), .is_input(oe),
    .det_rise(rise), .det_fall(fall), .det_high(lhi), .det_low(llo),
    .event_hit(hit)
  );

  gpio_bank_regs #(.NLINES(NLINES), .DBT_W(DBT_W), .REVISION(REVISION)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .event_hit(hit),
    .oe_q(oe), .dout_q(dout), .rise_q(rise), .fall_q(fall),
    .lhi_q(lhi), .llo_q(llo), .st_a_q(st_a), .st_b_q(st_b),
    .en_a_q(en_a), .en_b_q(en_b), .cfg_q(cfg),
    .irq_a_q(irq_a), .irq_b_q(irq_b), .wake_q(wake_req)
  );

  assign pad_out   = dout;
  assign pad_drive = ~oe;
endmodule

// File: rtl/gpio_dual_irq_bank_chk.sv
module gpio_dual_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NLINES = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NLINES-1:0] st_a,
  input logic [NLINES-1:0] en_a,
  input logic [NLINES-1:0] st_b,
  input logic [NLINES-1:0] en_b,
  input logic [CFG_W-1:0]  cfg,
  input logic [NLINES-1:0] pad_drive,
  input logic              irq_a,
  input logic              irq_b,
  input logic              wake_req
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_a && !irq_b && !wake_req && pad_drive == '0));

  assert_irq_match_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_a == |(st_a & en_a)) && (irq_b == |(st_b & en_b)));

  assert_status_clear_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (|($past(st_a) & ~st_a)) |->
      $past(bus_sel && bus_wr &&
            (bus_addr == A_STA || (bus_addr == A_CFG && bus_wdata[CFG_SRST_BIT]))));

  assert_wake_rise_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_req) |-> $past(cfg[CFG_WAKE_BIT] && cfg[4:3] != 2'b00));

  assert_wake_fall_cause_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_req) |->
      $past(bus_sel && bus_wr &&
            (bus_addr == A_WEN_C || (bus_addr == A_CFG && bus_wdata[CFG_SRST_BIT]))));
endmodule

bind gpio_dual_irq_bank gpio_dual_irq_bank_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .st_a(st_a), .en_a(en_a), .st_b(st_b), .en_b(en_b), .cfg(cfg),
  .pad_drive(pad_drive), .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req)
);

// File: tb/gpio_dual_irq_bank_test.sv
module gpio_dual_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pin_in = '0, pad_out, pad_drive;
  logic        irq_a, irq_b, wake_req;

  int total = 0, bad = 0;
  bit done = 0;

  gpio_dual_irq_bank uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_out(pad_out), .pad_drive(pad_drive),
    .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_status(input logic [31:0] p0, input logic [31:0] p1,
      input logic [31:0] oe, input logic [31:0] r, input logic [31:0] f,
      input logic [31:0] h, input logic [31:0] l);
    return oe & ((h & (p0 | p1)) | (l & (~p0 | ~p1)) | (r & p1 & ~p0) | (f & p0 & ~p1));
  endfunction

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_a", {31'd0, irq_a}, 32'd0);
    chk("R1 irq_b", {31'd0, irq_b}, 32'd0);
    chk("R1 wake", {31'd0, wake_req}, 32'd0);
    chk("R1 pad_drive", pad_drive, 32'd0);
    rdchk("R1 oe", 8'h34, 32'hFFFF_FFFF);
    rdchk("R1 ctrl", 8'h30, 32'd2);
    rdchk("R1 sysstatus", 8'h14, 32'd1);
    rdchk("R1 revision", 8'h00, 32'h25);
    rdchk("R1 cfg", 8'h10, 32'd0);
    rdchk("R1 status a", 8'h18, 32'd0);
    rdchk("R1 enable b", 8'h2C, 32'd0);
    rdchk("R1 level high", 8'h44, 32'd0);
    rdchk("R1 debounce time", 8'h54, 32'd0);

    // R2 masks and debounce storage
    wr(8'h10, 32'hFFFF_FFFD);
    rdchk("R2 cfg mask", 8'h10, 32'h1D);
    wr(8'h30, 32'hFFFF_FFFF);
    rdchk("R2 ctrl mask", 8'h30, 32'h7);
    wr(8'h50, 32'hA5A5_0F0F);
    rdchk("R2 debounce enable", 8'h50, 32'hA5A5_0F0F);
    wr(8'h54, 32'h0000_01C3);
    rdchk("R2 debounce time", 8'h54, 32'hC3);
    wr(8'h10, 32'h2);

    // R3 aliases
    wr(8'h64, 32'h0000_000F); wr(8'h60, 32'h0000_0005);
    rdchk("R3 enable a", 8'h1C, 32'h0A);
    rdchk("R3 enable a alias read", 8'h60, 32'h0A);
    wr(8'h2C, 32'hF000_0000); wr(8'h74, 32'h1); wr(8'h70, 32'h1000_0000);
    rdchk("R3 enable b", 8'h74, 32'hE000_0001);
    wr(8'h84, 32'h0000_0300); wr(8'h80, 32'h0000_0100);
    rdchk("R3 wake enable", 8'h20, 32'h200);
    wr(8'h3C, 32'h1234_5678); wr(8'h94, 32'h8000_0000); wr(8'h90, 32'h0000_0078);
    rdchk("R3 data out", 8'h90, 32'h9234_5600);
    chk("R3 pad_out", pad_out, 32'h9234_5600);

    // R4 read-only registers
    pin_in = 32'hCAFE_0001;
    wr(8'h38, 32'h0);
    wr(8'h00, 32'hFF);
    wr(8'h14, 32'h0);
    rdchk("R4 data in", 8'h38, 32'hCAFE_0001);
    rdchk("R4 revision", 8'h00, 32'h25);
    rdchk("R4 sysstatus", 8'h14, 32'd1);

    // R12 unmapped
    wr(8'h24, 32'hFFFF_FFFF);
    rdchk("R12 unmapped read", 8'h24, 32'd0);
    rdchk("R12 oe untouched", 8'h34, 32'hFFFF_FFFF);

    // R5 edges
    pins(32'h0);
    wr(8'h10, 32'h2);
    wr(8'h48, 32'h0000_0001); wr(8'h4C, 32'h0000_0002);
    pins(32'h0000_0003);
    rdchk("R5 rise in A", 8'h18, 32'h1);
    rdchk("R5 rise in B", 8'h28, 32'h1);
    pins(32'h0);
    rdchk("R5 fall in A", 8'h18, 32'h3);

    // R9 independent clears, R8 irq routing
    wr(8'h1C, 32'h2);
    chk("R8 irq_a set", {31'd0, irq_a}, 32'd1);
    chk("R8 irq_b clear", {31'd0, irq_b}, 32'd0);
    wr(8'h18, 32'h2);
    rdchk("R9 A partly cleared", 8'h18, 32'h1);
    rdchk("R9 B untouched", 8'h28, 32'h3);
    chk("R8 irq_a after clear", {31'd0, irq_a}, 32'd0);
    wr(8'h2C, 32'h1);
    chk("R8 irq_b set", {31'd0, irq_b}, 32'd1);

    // R6 level re-assert
    wr(8'h10, 32'h2);
    pins(32'h0000_0010);
    wr(8'h44, 32'h0000_0010);
    wr(8'h18, 32'hFFFF_FFFF);
    rdchk("R6 level re-asserts", 8'h18, 32'h10);
    pins(32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rdchk("R6 level gone stays clear", 8'h18, 32'h0);
    rdchk("R6 B still holds", 8'h28, 32'h10);

    // R7 output lines
    wr(8'h10, 32'h2);
    wr(8'h34, 32'hFFFF_0000);
    wr(8'h3C, 32'h1234_5678);
    chk("R7 pad_drive", pad_drive, 32'h0000_FFFF);
    chk("R7 pad_out", pad_out, 32'h1234_5678);
    wr(8'h48, 32'hFFFF_FFFF);
    pins(32'h0001_FFFF);
    rdchk("R7 no events on outputs", 8'h18, 32'h0001_0000);

    // R11 wakeup
    wr(8'h10, 32'h2);
    pins(32'h0);
    wr(8'h84, 32'h1); wr(8'h48, 32'h1);
    wr(8'h10, 32'h04);
    pins(32'h1);
    chk("R11 no wake with idle field 0", {31'd0, wake_req}, 32'd0);
    pins(32'h0);
    wr(8'h10, 32'h1C);
    pins(32'h1);
    chk("R11 wake raised", {31'd0, wake_req}, 32'd1);
    wr(8'h18, 32'hFFFF_FFFF);
    chk("R11 wake sticky", {31'd0, wake_req}, 32'd1);
    wr(8'h80, 32'h0);
    chk("R11 wake cleared by alias", {31'd0, wake_req}, 32'd0);

    // R10 soft reset
    wr(8'h1C, 32'hFF);
    wr(8'h10, 32'h0000_000A);
    rdchk("R10 cfg after soft reset", 8'h10, 32'h08);
    rdchk("R10 enable a", 8'h1C, 32'h0);
    rdchk("R10 oe", 8'h34, 32'hFFFF_FFFF);
    rdchk("R10 rising", 8'h48, 32'h0);
    rdchk("R10 ctrl", 8'h30, 32'd2);

    // R5 R6 R7 R8 random trials
    for (int t = 0; t < 40; t++) begin
      logic [31:0] p0, p1, oe, r, f, h, l, ea, e;
      p0 = $urandom; p1 = $urandom; oe = $urandom;
      r = $urandom; f = $urandom; h = $urandom & $urandom; l = $urandom & $urandom;
      ea = $urandom & $urandom & $urandom;
      pins(p0);
      wr(8'h10, 32'h2);
      wr(8'h34, oe); wr(8'h48, r); wr(8'h4C, f);
      wr(8'h44, h); wr(8'h40, l); wr(8'h1C, ea);
      pins(p1);
      e = exp_status(p0, p1, oe, r, f, h, l);
      rdchk("R5/R6/R7 random status A", 8'h18, e);
      rdchk("R5/R6/R7 random status B", 8'h28, e);
      chk("R8 random irq_a", {31'd0, irq_a}, {31'd0, |(e & ea)});
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule